// File: doc/BRIEF.md
# Four-Phase Charge Transfer Clock Sequencer

This block produces the four logic-level gate control levels that move charge packets along a four-gate-per-pixel CCD shift register. The four phases, called A, B, C and D here, follow an overlapping pattern. Two neighbouring phases are always high, which forms a collecting well under their gates. The other two are low and form a barrier. Each advance moves the well one gate forward. Four advances carry every packet by exactly one pixel and bring the phases back to the resting pattern.

A controller requests a transfer with a one-cycle `start` strobe and a pixel count. The sequencer then raises `busy` and advances one step on each cycle where `step_en` is high, so the enable strobe sets the transfer rate. After four steps per requested pixel it drops `busy`, emits a one-cycle `done` pulse and parks with A and B high. Level translation to the sensor's bipolar gate voltages is done outside the block.

Top module: `ccd_phase_seq`

## Requirements
- R1: After synchronous reset, `phase_a` and `phase_b` are 1, `phase_c` and `phase_d` are 0, `busy` is 0 and `done` is 0.
- R2: On every cycle outside reset, exactly two phases are high, and they are an adjacent pair: AB, BC, CD or DA (D is adjacent to A).
- R3: Each advance moves the pattern one place, in the order AB to BC to CD to DA to AB. On each advance exactly one phase rises and one phase falls, both on the same clock edge.
- R4: The phases advance only on a rising edge where `busy` and `step_en` are both 1. On every other edge all four phases hold their values.
- R5: A `start` pulse while idle with nonzero `pixel_count` N sets `busy` at that edge and schedules exactly 4·N advances.
- R6: The edge that performs the 4·N-th advance clears `busy` and sets `done` for exactly one cycle. At that point the phases are back at A and B high.
- R7: A `start` pulse while `busy` is 1 is ignored. The running transfer keeps its original step count.
- R8: A `start` pulse with `pixel_count` equal to 0 is ignored. `busy` and `done` stay 0 and the phases stay at rest.
- R9: `step_en` while idle has no effect on the phases.
- R10: The largest `pixel_count` (all ones, 255 with the default width) produces the full 4·255 advances before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| pixel_count | input | CNT_W | Number of pixels to shift, sampled with `start` |
| step_en | input | 1 | Advance strobe; one step per high cycle while busy |
| phase_a | output | 1 | Gate phase A level (registered) |
| phase_b | output | 1 | Gate phase B level (registered) |
| phase_c | output | 1 | Gate phase C level (registered) |
| phase_d | output | 1 | Gate phase D level (registered) |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle pulse on the final advance |

## Verification
The bench targets the final advance of a transfer. A counter that is off by one would drop `busy` one step early or late and leave the phases parked at DA or BC instead of AB. Gaps in `step_en` are mixed into the stimulus, so a design that advanced on every busy cycle would run ahead of the model. Start pulses that arrive during a transfer or with a zero count are also applied: a design that accepted them would restart or extend the step count, or raise `busy` with no work to do. The maximum count checks that the step counter is wide enough for 4·N without wrapping, because a wrapping counter would finish after a fraction of the requested pixels.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  localparam int NUM_PH = 4;
  localparam int IDX_W  = 2;

  typedef enum logic [IDX_W-1:0] {
    PAIR_AB = 2'd0,
    PAIR_BC = 2'd1,
    PAIR_CD = 2'd2,
    PAIR_DA = 2'd3
  } pair_e;

  // Index of the pair that follows a given pair in the transfer rotation.
  function automatic pair_e next_pair(input pair_e p);
    return pair_e'(p + 2'd1);
  endfunction
endpackage

// File: rtl/ccd_phase_ring.sv
module ccd_phase_ring
  import ccd_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [NUM_PH-1:0] gate
);
  pair_e cur_pair;
  pair_e nxt_pair;

  assign nxt_pair = next_pair(cur_pair);

  always_ff @(posedge clk) begin
    if (rst)      cur_pair <= PAIR_AB;
    else if (adv) cur_pair <= nxt_pair;
  end

  // Each gate bit is its own register, loaded with the decoded next pair,
  // so rise and fall land on the same edge.
  for (genvar i = 0; i < NUM_PH; i++) begin : g_gate
    localparam logic [IDX_W-1:0] SELF  = IDX_W'(i);
    localparam logic [IDX_W-1:0] PREV  = IDX_W'((i + NUM_PH - 1) % NUM_PH);
    localparam logic             RST_V = (i < 2);
    always_ff @(posedge clk) begin
      if (rst)      gate[i] <= RST_V;
      else if (adv) gate[i] <= (nxt_pair == SELF) || (nxt_pair == PREV);
    end
  end

  // R2
  two_high_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gate) == 2 &&
    (gate == 4'b0011 || gate == 4'b0110 || gate == 4'b1100 || gate == 4'b1001));

  // R3
  rotate_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> gate == {$past(gate[NUM_PH-2:0]), $past(gate[NUM_PH-1])});

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(gate));
endmodule

// File: rtl/ccd_step_counter.sv
module ccd_step_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] pixel_count,
  input  logic             step_en,
  output logic             adv,
  output logic             busy,
  output logic             done
);
  localparam int REM_W = CNT_W + 2;

  logic [REM_W-1:0] remaining;
  logic             accept;
  logic             last_step;

  assign accept    = start && !busy && (pixel_count != '0);
  assign adv       = busy && step_en;
  assign last_step = adv && (remaining == REM_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= last_step;
      if (accept) begin
        remaining <= {pixel_count, 2'b00};
        busy      <= 1'b1;
      end else if (adv) begin
        remaining <= remaining - REM_W'(1);
        if (last_step) busy <= 1'b0;
      end
    end
  end

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && pixel_count != '0) |=> busy);

  // R8
  zero_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && pixel_count == '0) |=> !busy);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/ccd_phase_seq.sv
module ccd_phase_seq
  import ccd_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] pixel_count,
  input  logic             step_en,
  output logic             phase_a,
  output logic             phase_b,
  output logic             phase_c,
  output logic             phase_d,
  output logic             busy,
  output logic             done
);
  logic              adv;
  logic [NUM_PH-1:0] gate;

  ccd_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .pixel_count (pixel_count),
    .step_en     (step_en),
    .adv         (adv),
    .busy        (busy),
    .done        (done)
  );

  ccd_phase_ring u_ring (
    .clk  (clk),
    .rst  (rst),
    .adv  (adv),
    .gate (gate)
  );

  assign phase_a = gate[0];
  assign phase_b = gate[1];
  assign phase_c = gate[2];
  assign phase_d = gate[3];

  // R6
  park_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (phase_a && phase_b && !phase_c && !phase_d));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && step_en) |=> $stable(gate));
endmodule

// File: tb/sim_ccd_phase_seq.sv
module sim_ccd_phase_seq;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst, start, step_en;
  logic [CNT_W-1:0] pixel_count;
  logic phase_a, phase_b, phase_c, phase_d, busy, done;

  always #2 clk = ~clk;

  ccd_phase_seq #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .pixel_count(pixel_count),
    .step_en(step_en), .phase_a(phase_a), .phase_b(phase_b),
    .phase_c(phase_c), .phase_d(phase_d), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m_gate;
  logic       m_busy, m_done;
  int         m_rem;

  function automatic logic [3:0] rot(input logic [3:0] g);
    return {g[2:0], g[3]};
  endfunction

  function automatic logic pair_ok(input logic [3:0] g);
    return g == 4'b0011 || g == 4'b0110 || g == 4'b1100 || g == 4'b1001;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // One clock cycle: drive at the falling edge, advance the model at the
  // rising edge, compare just after it.
  task automatic cyc(input logic s, input logic [CNT_W-1:0] n, input logic e);
    logic [3:0] g;
    @(negedge clk);
    start = s; pixel_count = n; step_en = e;
    @(posedge clk);
    m_done = 1'b0;
    if (rst) begin
      m_gate = 4'b0011; m_busy = 1'b0; m_rem = 0;
    end else if (m_busy && e) begin
      m_gate = rot(m_gate);
      m_rem--;
      if (m_rem == 0) begin m_busy = 1'b0; m_done = 1'b1; end
    end else if (!m_busy && s && n != 0) begin
      m_busy = 1'b1; m_rem = 4 * int'(n);
    end
    #1;
    g = {phase_d, phase_c, phase_b, phase_a};
    chk("R3 phases", int'(g), int'(m_gate));
    chk("R2 adjacent pair", int'(pair_ok(g)), 1);
    chk("R5 busy", int'(busy), int'(m_busy));
    chk("R6 done", int'(done), int'(m_done));
  endtask

  task automatic run_until_idle(input int en_pct);
    int guard = 0;
    while (m_busy && guard < 5000) begin
      cyc(1'b0, '0, ($urandom % 100) < en_pct);
      guard++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    int seen;
    void'($urandom(32'd1357));
    rst = 1'b1; start = 1'b0; step_en = 1'b0; pixel_count = '0;
    cyc(0, 0, 0); cyc(0, 0, 0);
    // R1 reset state
    chk("R1 reset phases", int'({phase_d, phase_c, phase_b, phase_a}), 4'b0011);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    @(negedge clk); rst = 1'b0;

    // R9 step_en while idle
    repeat (5) cyc(0, 0, 1);
    chk("R9 idle phases", int'({phase_d, phase_c, phase_b, phase_a}), 4'b0011);

    // R8 zero count start
    cyc(1, 0, 1);
    cyc(0, 0, 1);
    chk("R8 zero ignored busy", int'(busy), 0);

    // R3 directed order over one pixel with continuous enable
    cyc(1, 1, 0);
    cyc(0, 0, 1); chk("R3 step BC", int'({phase_d, phase_c, phase_b, phase_a}), 4'b0110);
    cyc(0, 0, 1); chk("R3 step CD", int'({phase_d, phase_c, phase_b, phase_a}), 4'b1100);
    cyc(0, 0, 1); chk("R3 step DA", int'({phase_d, phase_c, phase_b, phase_a}), 4'b1001);
    cyc(0, 0, 1); chk("R6 parked AB", int'({phase_d, phase_c, phase_b, phase_a}), 4'b0011);
    chk("R6 done at last step", int'(done), 1);
    cyc(0, 0, 1); chk("R6 done one cycle", int'(done), 0);

    // R4 sparse enable: hold while step_en low
    cyc(1, 2, 0);
    cyc(0, 0, 0); cyc(0, 0, 0);
    chk("R4 hold without enable", int'({phase_d, phase_c, phase_b, phase_a}), 4'b0011);
    run_until_idle(30);

    // R7 start while busy with a different count
    cyc(1, 1, 0);
    cyc(1, 9, 1); cyc(1, 9, 1);
    seen = 0;
    while (m_busy) begin cyc(1, 7, 1); seen++; end
    chk("R7 original count kept", seen, 2);

    // Random transfers
    for (int k = 0; k < 40; k++) begin
      cyc(1, CNT_W'(1 + ($urandom % 12)), ($urandom % 2) == 1);
      run_until_idle(20 + int'($urandom % 80));
      repeat ($urandom % 3) cyc(($urandom % 2) == 1, '0, ($urandom % 2) == 1);
    end

    // R10 maximum count
    cyc(1, {CNT_W{1'b1}}, 0);
    seen = 0;
    while (m_busy) begin cyc(0, 0, 1); seen++; end
    chk("R10 max count steps", seen, 4 * ((1 << CNT_W) - 1));
    chk("R10 done at max", int'(done), 1);

    // R1 reset mid-transfer
    cyc(1, 3, 1); cyc(0, 0, 1);
    @(negedge clk); rst = 1'b1;
    cyc(0, 0, 1);
    chk("R1 reset mid-run", int'({busy, phase_d, phase_c, phase_b, phase_a}), 5'b00011);
    @(negedge clk); rst = 1'b0;
    cyc(0, 0, 0);
    finish_run();
  end
endmodule